// File: doc/BRIEF.md
# First-Order Recursive Low-Pass Smoother

This block smooths a stream of 16-bit unsigned samples with a single-pole recursive low-pass response. The feedback coefficient is 1/256. Each accepted sample moves the running state 1/256 of the way toward the new input. There is no multiplier. The state keeps 16 integer bits and 16 fractional bits in a 32-bit accumulator. On every sample the accumulator loses its own value shifted right by 8. It then gains the input shifted left by 8, plus a small per-sample bias. After that the low 8 bits are cleared, so only 24 significant bits survive.

If the result is simply truncated, a full-scale input can settle one step short of full scale. Two remedies can be chosen while the block runs. The first is a larger per-sample bias that shifts the average truncation error upward. The second is an output stage that rounds to nearest, and that stage saturates instead of wrapping. A 2-bit control input selects the bias and the output stage. The block captures that control only on cycles with no sample or during reset.

There is one clock, and a synchronous active-high reset clears the state. Each accepted sample produces a registered result one clock later.

Top module: `iir_lp1`

## Requirements
- R1: While reset is high and on the first cycle after it, the accumulator is zero, `out_valid` is 0 and `out_data` is 0x0000.
- R2: For each accepted sample x, the new accumulator is (A - (A >> 8) + (x << 8) + bias) with its low 8 bits forced to zero, where A is the previous 32-bit accumulator.
- R3: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low in every other cycle.
- R4: `out_data` and the accumulator keep their values in any cycle that follows a cycle without an accepted sample.
- R5: With mode bit 1 = 0 (truncating), `out_data` is bits 31:16 of the new accumulator.
- R6: With mode bit 1 = 1 (rounding), `out_data` is bits 31:16 of (accumulator + 0x8000). If that addition carries out of 32 bits, `out_data` is 0xFFFF.
- R7: Mode bit 0 picks the bias: 0 selects 0x80 and 1 selects 0xFF.
- R8: The mode is captured only in cycles where reset is high or `in_valid` is low. A sample uses the mode captured most recently before it, so a mode change presented together with a sample does not affect that sample.
- R9: With bias 0x80 and a constant input of 0xFFFF from a zero state, the truncating output settles at 0xFFFE. Switching to rounding then gives 0xFFFF.
- R10: With bias 0xFF and a constant input of 0xFFFF, the truncating output settles at 0xFFFF.
- R11: The low 8 bits of the accumulator are always zero, and the update never carries out of 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Bit 1 selects rounding output, bit 0 selects bias 0xFF over 0x80 |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Unsigned input sample |
| out_valid | output | 1 | High one cycle after each accepted sample |
| out_data | output | 16 | Filtered unsigned output, held between samples |

## Verification
The bench builds the block with its default parameters: 16-bit data, 16 fractional bits, a shift of 8 and 24 kept bits. These values make the full-scale corner reachable within a few thousand samples, which is where truncation stalls one step short. Long runs of 0xFFFF under each bias and output mode show the settled values. A small input after reset places the fraction exactly at one half, so rounding and truncation give different outputs. This makes it visible when a mode change arrives together with a sample and is ignored.

// File: rtl/iir_pkg.sv
package iir_pkg;
  typedef struct packed {
    logic round_en;
    logic bias_hi;
  } iir_mode_t;
endpackage

// File: rtl/iir_mode_reg.sv
module iir_mode_reg
  import iir_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      busy_i,
  input  iir_mode_t mode_i,
  output iir_mode_t mode_o
);
  iir_mode_t mode_q;

  // Capture only while reset or between samples
  always_ff @(posedge clk) begin
    if (rst || !busy_i) mode_q <= mode_i;
  end

  assign mode_o = mode_q;

  // R8: a sample cycle leaves the captured mode untouched
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(mode_q));
endmodule

// File: rtl/iir_acc_core.sv
module iir_acc_core #(
  parameter int DATA_W  = 16,
  parameter int FRAC_W  = 16,
  parameter int SHIFT   = 8,
  parameter int KEEP_W  = 24,
  parameter int BIAS_LO = 'h80,
  parameter int BIAS_HI = 'hFF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step_i,
  input  logic                     bias_hi_i,
  input  logic [DATA_W-1:0]        din_i,
  output logic [DATA_W+FRAC_W-1:0] acc_next_o,
  output logic [DATA_W+FRAC_W-1:0] acc_o
);
  localparam int ACC_W  = DATA_W + FRAC_W;
  localparam int TRIM_W = ACC_W - KEEP_W;
  localparam int IN_SH  = FRAC_W - SHIFT;
  localparam logic [ACC_W-1:0] KEEP_MASK = {{KEEP_W{1'b1}}, {TRIM_W{1'b0}}};

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   fb_x, din_x, bias_x, sum_x;

  always_comb begin
    fb_x   = {1'b0, acc_q >> SHIFT};
    din_x  = {{(ACC_W+1-DATA_W){1'b0}}, din_i} << IN_SH;
    bias_x = bias_hi_i ? (ACC_W+1)'(BIAS_HI) : (ACC_W+1)'(BIAS_LO);
    sum_x  = {1'b0, acc_q} - fb_x + din_x + bias_x;
    acc_next_o = sum_x[ACC_W-1:0] & KEEP_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst)         acc_q <= '0;
    else if (step_i) acc_q <= acc_next_o;
  end

  assign acc_o = acc_q;

  // R1: state is clear right after reset
  a_r1_acc_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> acc_q == '0);
  // R11: trimmed bits stay zero
  a_r11_trim_zero: assert property (@(posedge clk) disable iff (rst)
    acc_q[TRIM_W-1:0] == '0);
  // R11: update never carries out of the accumulator
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    step_i |-> !sum_x[ACC_W]);
  // R4: no sample, no state change
  a_r4_acc_hold: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(acc_q));
endmodule

// File: rtl/iir_out_stage.sv
module iir_out_stage #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  logic                     round_i,
  input  logic [DATA_W+FRAC_W-1:0] acc_i,
  output logic                     valid_o,
  output logic [DATA_W-1:0]        data_o
);
  localparam int ACC_W = DATA_W + FRAC_W;
  localparam logic [ACC_W:0] HALF = (ACC_W+1)'(1) << (FRAC_W - 1);

  logic [ACC_W:0]      rsum;
  logic [DATA_W-1:0]   trunc_v, round_v, sel_v;

  always_comb begin
    trunc_v = acc_i[ACC_W-1:FRAC_W];
    rsum    = {1'b0, acc_i} + HALF;
    round_v = rsum[ACC_W] ? {DATA_W{1'b1}} : rsum[ACC_W-1:FRAC_W];
    sel_v   = round_i ? round_v : trunc_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) data_o <= sel_v;
    end
  end

  // R6: rounding never lands below the truncated value (no wrap)
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (load_i && round_i) |-> round_v >= trunc_v);
  // R4: output held between samples
  a_r4_out_hold: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(data_o));
endmodule

// File: rtl/iir_lp1.sv
module iir_lp1
  import iir_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FRAC_W  = 16,
  parameter int SHIFT   = 8,
  parameter int KEEP_W  = 24,
  parameter int BIAS_LO = 'h80,
  parameter int BIAS_HI = 'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int ACC_W = DATA_W + FRAC_W;

  iir_mode_t        mode_cur;
  logic [ACC_W-1:0] acc_next, acc_cur;

  iir_mode_reg u_mode (
    .clk    (clk),
    .rst    (rst),
    .busy_i (in_valid),
    .mode_i (iir_mode_t'(mode)),
    .mode_o (mode_cur)
  );

  iir_acc_core #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .SHIFT(SHIFT), .KEEP_W(KEEP_W),
    .BIAS_LO(BIAS_LO), .BIAS_HI(BIAS_HI)
  ) u_acc (
    .clk        (clk),
    .rst        (rst),
    .step_i     (in_valid),
    .bias_hi_i  (mode_cur.bias_hi),
    .din_i      (in_data),
    .acc_next_o (acc_next),
    .acc_o      (acc_cur)
  );

  iir_out_stage #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load_i  (in_valid),
    .round_i (mode_cur.round_en),
    .acc_i   (acc_next),
    .valid_o (out_valid),
    .data_o  (out_data)
  );

  // R3: one result per sample, one cycle later
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r3_valid_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R5: truncated result matches the stored state
  a_r5_trunc_match: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode_cur.round_en) |=> out_data == acc_cur[ACC_W-1:FRAC_W]);
endmodule

// File: tb/sim_iir_lp1.sv
module sim_iir_lp1;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int errs = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R1";

  longint unsigned m_acc = 0;
  logic [1:0]      m_mode = 2'b00;
  logic            exp_v = 1'b0;
  logic [15:0]     exp_d = '0;

  always #5 clk = ~clk;

  iir_lp1 u0 (
    .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  // Behavioural reference, evaluated on each rising edge
  always @(posedge clk) begin
    longint unsigned nxt, r;
    if (rst) begin
      m_acc = 0; exp_v = 1'b0; exp_d = '0; m_mode = mode;
    end else if (in_valid) begin
      nxt = m_acc - (m_acc >> 8) + (longint'(in_data) << 8)
            + (m_mode[0] ? 64'hFF : 64'h80);
      nxt = nxt & 64'hFFFF_FF00;
      m_acc = nxt;
      if (m_mode[1]) begin
        r = nxt + 64'h8000;
        exp_d = (r > 64'hFFFF_FFFF) ? 16'hFFFF : 16'(r >> 16);
      end else begin
        exp_d = 16'(nxt >> 16);
      end
      exp_v = 1'b1;
    end else begin
      exp_v = 1'b0;
      m_mode = mode;
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Compare against the model every cycle, away from the edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 1) begin
      check("R3", {15'b0, out_valid}, {15'b0, exp_v});
      check(tag, out_data, exp_d);
    end
    if (cycles > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic feed(logic [15:0] v, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = v;
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk); mode = m;
    @(negedge clk);
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    check("R1", {15'b0, out_valid}, 16'h0000);
    check("R1", out_data, 16'h0000);
    rst = 1'b0;

    // R8/R6: mode change arriving with a sample is ignored
    tag = "R8";
    @(negedge clk); in_valid = 1'b1; in_data = 16'h0080; mode = 2'b10;
    @(negedge clk); in_valid = 1'b0;
    check("R8", out_data, 16'h0000);
    tag = "R6";
    feed(16'h0000, 1);
    check("R6", out_data, 16'h0001);
    repeat (4) @(negedge clk);
    check("R4", out_data, 16'h0001);

    // R9: bias 0x80, truncation stalls one step short
    @(negedge clk); rst = 1'b1; mode = 2'b00;
    @(negedge clk); rst = 1'b0;
    tag = "R9";
    feed(16'hFFFF, 4000);
    check("R9", out_data, 16'hFFFE);
    set_mode(2'b10);
    feed(16'hFFFF, 40);
    check("R9", out_data, 16'hFFFF);

    // R10 / R7: larger bias with truncation reaches full scale
    tag = "R10";
    set_mode(2'b01);
    feed(16'hFFFF, 4000);
    check("R10", out_data, 16'hFFFF);
    tag = "R6";
    set_mode(2'b11);
    feed(16'hFFFF, 20);
    check("R6", out_data, 16'hFFFF);

    // R2/R5/R7: mixed stimulus with gaps and mode changes
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", out_data, 16'h0000);
    tag = "R2";
    feed(16'h1234, 300);
    tag = "R5";
    set_mode(2'b01);
    for (int k = 0; k < 200; k++) begin
      feed(16'((k * 40503) ^ 16'h5A5A), 1 + (k % 3));
      if (k % 5 == 0) @(negedge clk);
    end
    tag = "R7";
    set_mode(2'b11);
    feed(16'h8001, 150);
    set_mode(2'b00);
    feed(16'h0000, 600);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule